// File: doc/BRIEF.md
# Two-Wire Command Slave with Strapped Address

This block is a slave on a byte-oriented two-wire serial bus. It sits inside a smart card interface controller and gives a host access to a small bank of configuration registers. The clock and data lines are oversampled with the system clock. Each line passes through a two-flop synchronizer and a short glitch filter. START and STOP conditions are found on the filtered lines. The slave drives the data line only as an open-drain pull-down, through `sda_oe_o`.

Two bits of the 7-bit slave address come from two shared pins. The block captures them on the first clock after a hardware reset, and again after a general-call soft reset. The latched value is then held, so the pins are free for other functions.

A write transfer carries a command byte that sets the register pointer, followed by data bytes that are stored at consecutive addresses. A read transfer carries no command byte: the slave returns bytes straight after the address, starting at the status register. Several transfers can be chained with repeated STARTs inside one frame, and the frame ends at STOP.

Top module: `twi_cmd_slave`

## Requirements
- R1: The slave acknowledges an address byte equal to binary 0100,A2,A1,1 followed by the R/W bit, where R/W=0 means write and R/W=1 means read. It never pulls SDA low for any other address except the general call, and it ignores the rest of a frame it did not acknowledge.
- R2: A2 and A1 are the values on `strap_a2_i` and `strap_a1_i` one clock after `rst_n` rises, or one clock after a general-call soft reset. Later changes on those pins do not change the address or the status register.
- R3: In a write transfer, the byte after the address is a command byte whose low log2(NREGS) bits load the pointer. Each following data byte is written at the pointer and acknowledged, and the pointer then increments, wrapping from NREGS-1 to 0.
- R4: In a read transfer, the slave returns register 0 first and then consecutive registers, one per byte, for as long as the master acknowledges.
- R5: After the master answers a read byte with NACK, the slave releases SDA and drives nothing until the next START or STOP.
- R6: A general-call address byte 0x00 followed by data 0x06 is acknowledged on both bytes, restores every register to its default and re-samples A2/A1. A general call followed by any other data byte is not acknowledged and changes nothing.
- R7: A repeated START at any point returns the slave to the address phase, so that write and read transfers can be chained within one frame.
- R8: Register 0 is a read-only status byte whose value is {6'b0, A2, A1}. Writes aimed at it are acknowledged but have no effect.
- R9: After reset, register i (for i of 1 or more) holds i*0x11, truncated to 8 bits.
- R10: A pulse on SCL or SDA shorter than FILT_LEN system clocks is ignored. It causes no extra bit and no false START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 MHz |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_a2_i | input | 1 | Shared pin giving address bit A2 at reset |
| strap_a1_i | input | 1 | Shared pin giving address bit A1 at reset |

## Verification
The bench moves the strap pins after reset and checks two things: the old address still acknowledges, and the new address is refused. A slave that samples the pins continuously fails both checks. A pointer-wrap write sends three bytes starting at the last register. A design with a wrong wrap corrupts register 1, or lets register 0 become writable.

The bench injects single-cycle pulses on SCL, and on SDA while SCL is high. A missing filter shows up either as a shifted byte or as a phantom START. Other cases covered are the master NACK (a slave that keeps transmitting pulls the line low on the next clock) and a general call with a non-reset code, which must leave the registers untouched. Random writes, with random command bytes and burst lengths, are compared against a bench model of the register bank.

// File: rtl/twi_pkg.sv
package twi_pkg;

   localparam logic [3:0] ADDR_HI   = 4'b0100;
   localparam logic [7:0] GC_ADDR   = 8'h00;
   localparam logic [7:0] GC_SRESET = 8'h06;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_GC,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_WAIT
   } twi_state_e;

   function automatic logic [7:0] reg_default(input int idx);
      return 8'((idx * 17) & 255);
   endfunction

endpackage

// File: rtl/twi_pin_filter.sv
module twi_pin_filter #(
   parameter int FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic filt_o,
   output logic rise_o,
   output logic fall_o
);

   logic s1, s2, filt_d;

   if (FILT_LEN < 1) begin : g_bad_len
      $error("twi_pin_filter: FILT_LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= pin_i;
         s2 <= s1;
      end
   end

   if (FILT_LEN == 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_o <= 1'b1;
         else        filt_o <= s2;
      end

      p_filter_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt_o) |-> $past(s2) == filt_o);
   end else begin : g_window
      logic [FILT_LEN-1:0] hist;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist   <= '1;
            filt_o <= 1'b1;
         end else begin
            hist <= {hist[FILT_LEN-2:0], s2};
            if (&hist)       filt_o <= 1'b1;
            else if (~|hist) filt_o <= 1'b0;
         end
      end

      p_filter_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt_o) |-> $past(hist[0]) == filt_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) filt_d <= 1'b1;
      else        filt_d <= filt_o;
   end

   assign rise_o = filt_o & ~filt_d;
   assign fall_o = ~filt_o & filt_d;

endmodule

// File: rtl/twi_strap_latch.sv
module twi_strap_latch #(
   parameter int ADDR_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst_i,
   input  logic [ADDR_BITS-1:0] strap_i,
   output logic [ADDR_BITS-1:0] addr_o
);

   logic pend;

   if (ADDR_BITS < 1) begin : g_bad_bits
      $error("twi_strap_latch: ADDR_BITS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b1;
         addr_o <= '0;
      end else if (soft_rst_i) begin
         pend <= 1'b1;
      end else if (pend) begin
         addr_o <= strap_i;
         pend   <= 1'b0;
      end
   end

   p_strap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !soft_rst_i) |=> $stable(addr_o));

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
   import twi_pkg::*;
#(
   parameter int NREGS = 8,
   parameter int PTR_W = $clog2(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             we_i,
   input  logic [PTR_W-1:0] waddr_i,
   input  logic [7:0]       wdata_i,
   input  logic [PTR_W-1:0] raddr_i,
   input  logic [7:0]       status_i,
   output logic [7:0]       rdata_o
);

   logic [7:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_status
         assign regs[i] = 8'h00;
      end else begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 regs[i] <= reg_default(i);
            else if (clr_i)                             regs[i] <= reg_default(i);
            else if (we_i && waddr_i == PTR_W'(i))      regs[i] <= wdata_i;
         end

         p_clr_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i |=> regs[i] == reg_default(i));
      end
   end

   assign rdata_o = (raddr_i == '0) ? status_i : regs[raddr_i];

endmodule

// File: rtl/twi_byte_engine.sv
module twi_byte_engine
   import twi_pkg::*;
#(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_f,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_f,
   input  logic             sda_rise,
   input  logic             sda_fall,
   input  logic [1:0]       addr_sel_i,
   input  logic [7:0]       rdata_i,
   output logic             sda_oe_o,
   output logic             we_o,
   output logic [PTR_W-1:0] ptr_o,
   output logic [7:0]       wdata_o,
   output logic             soft_rst_o
);

   twi_state_e state, next_st, nxt_now;
   logic [2:0] cnt;
   logic [7:0] shreg, txsh, byte_in;
   logic       drv, mack_ok, ack_now, done, rx_state, start_c, stop_c;
   logic [6:0] own_addr;

   assign own_addr = {ADDR_HI, addr_sel_i, 1'b1};
   assign start_c  = sda_fall & scl_f;
   assign stop_c   = sda_rise & scl_f;
   assign byte_in  = {shreg[6:0], sda_f};
   assign rx_state = (state == ST_ADDR) || (state == ST_CMD) ||
                     (state == ST_WDATA) || (state == ST_GC);
   assign done     = rx_state && scl_rise && (cnt == 3'd7);

   always_comb begin
      ack_now = 1'b0;
      nxt_now = ST_WAIT;
      unique case (state)
         ST_ADDR: begin
            if (byte_in[7:1] == own_addr) begin
               ack_now = 1'b1;
               nxt_now = byte_in[0] ? ST_TX : ST_CMD;
            end else if (byte_in == GC_ADDR) begin
               ack_now = 1'b1;
               nxt_now = ST_GC;
            end
         end
         ST_CMD, ST_WDATA: begin
            ack_now = 1'b1;
            nxt_now = ST_WDATA;
         end
         ST_GC: ack_now = (byte_in == GC_SRESET);
         default: ;
      endcase
   end

   assign we_o       = done && (state == ST_WDATA);
   assign soft_rst_o = done && (state == ST_GC) && (byte_in == GC_SRESET);
   assign wdata_o    = byte_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         next_st  <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txsh     <= '0;
         drv      <= 1'b0;
         mack_ok  <= 1'b0;
         sda_oe_o <= 1'b0;
         ptr_o    <= '0;
      end else if (start_c) begin
         state    <= ST_ADDR;
         cnt      <= '0;
         sda_oe_o <= 1'b0;
      end else if (stop_c) begin
         state    <= ST_IDLE;
         sda_oe_o <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR, ST_CMD, ST_WDATA, ST_GC: begin
               if (scl_rise) begin
                  shreg <= byte_in;
                  cnt   <= cnt + 3'd1;
                  if (cnt == 3'd7) begin
                     drv     <= 1'b0;
                     next_st <= nxt_now;
                     state   <= ack_now ? ST_ACK : ST_WAIT;
                     if (state == ST_CMD)   ptr_o <= byte_in[PTR_W-1:0];
                     if (state == ST_WDATA) ptr_o <= ptr_o + 1'b1;
                     if (state == ST_ADDR)  ptr_o <= '0;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  if (!drv) begin
                     drv      <= 1'b1;
                     sda_oe_o <= 1'b1;
                  end else begin
                     state <= next_st;
                     cnt   <= '0;
                     if (next_st == ST_TX) begin
                        txsh     <= rdata_i;
                        sda_oe_o <= ~rdata_i[7];
                        ptr_o    <= ptr_o + 1'b1;
                     end else begin
                        sda_oe_o <= 1'b0;
                     end
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (cnt == 3'd7) begin
                     sda_oe_o <= 1'b0;
                     mack_ok  <= 1'b0;
                     cnt      <= '0;
                     state    <= ST_MACK;
                  end else begin
                     cnt      <= cnt + 3'd1;
                     txsh     <= {txsh[6:0], 1'b0};
                     sda_oe_o <= ~txsh[6];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) mack_ok <= ~sda_f;
               if (scl_fall) begin
                  if (mack_ok) begin
                     txsh     <= rdata_i;
                     sda_oe_o <= ~rdata_i[7];
                     ptr_o    <= ptr_o + 1'b1;
                     cnt      <= '0;
                     state    <= ST_TX;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   p_wait_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !sda_oe_o);

   p_drive_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_f);

   p_write_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_o |=> (state == ST_ACK));

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe_o);

endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
   import twi_pkg::*;
#(
   parameter int NREGS    = 8,
   parameter int FILT_LEN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   input  logic strap_a2_i,
   input  logic strap_a1_i
);

   localparam int PTR_W = $clog2(NREGS);

   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0 || NREGS > 256) begin : g_bad_nregs
      $error("twi_cmd_slave: NREGS must be a power of two in 2..256");
   end

   logic             scl_f, scl_rise, scl_fall;
   logic             sda_f, sda_rise, sda_fall;
   logic [1:0]       addr_sel;
   logic             we, soft_rst;
   logic [PTR_W-1:0] ptr;
   logic [7:0]       wdata, rdata, status;

   twi_pin_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(scl_i),
      .filt_o(scl_f), .rise_o(scl_rise), .fall_o(scl_fall));

   twi_pin_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .pin_i(sda_i),
      .filt_o(sda_f), .rise_o(sda_rise), .fall_o(sda_fall));

   twi_strap_latch #(.ADDR_BITS(2)) u_strap (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst),
      .strap_i({strap_a2_i, strap_a1_i}), .addr_o(addr_sel));

   assign status = {6'b0, addr_sel};

   twi_byte_engine #(.PTR_W(PTR_W)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_f(scl_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_f(sda_f), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .addr_sel_i(addr_sel), .rdata_i(rdata),
      .sda_oe_o(sda_oe_o), .we_o(we), .ptr_o(ptr),
      .wdata_o(wdata), .soft_rst_o(soft_rst));

   twi_regfile #(.NREGS(NREGS), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .clr_i(soft_rst),
      .we_i(we), .waddr_i(ptr), .wdata_i(wdata),
      .raddr_i(ptr), .status_i(status), .rdata_o(rdata));

endmodule

// File: tb/twi_cmd_slave_bench.sv
module twi_cmd_slave_bench;

   localparam int NREGS = 8;
   localparam int Q     = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic strap_a2 = 1'b1, strap_a1 = 1'b0;
   logic sda_oe;
   logic sda_line;

   int checks = 0, errors = 0;
   logic [7:0] model [NREGS];
   logic lat_a2, lat_a1;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   twi_cmd_slave #(.NREGS(NREGS), .FILT_LEN(2)) u_twi_cmd_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_a2_i(strap_a2), .strap_a1_i(strap_a1));

   function automatic logic [7:0] def_val(int i);
      return 8'((i * 17) & 255);
   endfunction

   function automatic logic [7:0] adr(logic a2, logic a1, logic rw);
      return {4'b0100, a2, a1, 1'b1, rw};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NREGS; i++) model[i] = def_val(i);
   endtask

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   // glitch: 0 none, 1 scl low pulse, 2 sda low pulse (only on a 1 bit)
   task automatic send_bit(logic b, int glitch);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(Q / 2);
      if (glitch == 1) begin scl_m = 1'b0; tick(1); scl_m = 1'b1; end
      if (glitch == 2) begin sda_m = 1'b0; tick(1); sda_m = b; end
      tick(Q / 2);
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic write_byte(logic [7:0] v, output logic ack, input int gbit, input int gkind);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i], (i == gbit) ? gkind : 0);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic read_byte(logic give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack, 0);
   endtask

   task automatic read_check(string req);
      logic ack, b;
      logic [7:0] v;
      bus_start();
      write_byte(adr(lat_a2, lat_a1, 1'b1), ack, -1, 0);
      chk({req, " R1 read address ack"}, 8'(ack), 8'd1);
      model[0] = {6'b0, lat_a2, lat_a1};
      for (int i = 0; i < NREGS; i++) begin
         read_byte(i != NREGS - 1, v);
         chk({req, " R4 read byte"}, v, model[i]);
      end
      chk("R5 released after master NACK", 8'(sda_oe), 8'd0);
      recv_bit(b);
      chk("R5 line idle on extra clock", 8'(b), 8'd1);
      bus_stop();
   endtask

   task automatic write_regs(logic [7:0] cmd, int n, logic [7:0] d0, logic [7:0] d1,
                             logic [7:0] d2, int gbyte, int gkind);
      logic ack;
      logic [7:0] d [3];
      int p;
      d[0] = d0; d[1] = d1; d[2] = d2;
      bus_start();
      write_byte(adr(lat_a2, lat_a1, 1'b0), ack, -1, 0);
      chk("R1 write address ack", 8'(ack), 8'd1);
      write_byte(cmd, ack, -1, 0);
      chk("R3 command ack", 8'(ack), 8'd1);
      p = int'(cmd) % NREGS;
      for (int i = 0; i < n; i++) begin
         write_byte(d[i], ack, (i == gbyte) ? 3 : -1, gkind);
         chk("R3 data ack", 8'(ack), 8'd1);
         if (p != 0) model[p] = d[i];
         p = (p + 1) % NREGS;
      end
      bus_stop();
   endtask

   initial begin
      logic ack;
      logic [7:0] v;
      int n;
      void'($urandom(32'd4242));
      lat_a2 = 1'b1; lat_a1 = 1'b0;
      model_reset();
      tick(5);
      chk("R1 reset: SDA not driven", 8'(sda_oe), 8'd0);
      rst_n = 1'b1;
      tick(4);

      // R9 defaults and R8 status after reset
      read_check("R9 defaults");

      // R2: move the straps, the address must not follow
      strap_a2 = 1'b0; strap_a1 = 1'b1;
      tick(4);
      read_check("R2 straps held");
      bus_start();
      write_byte(adr(1'b0, 1'b1, 1'b0), ack, -1, 0);
      chk("R2 new strap address refused", 8'(ack), 8'd0);
      bus_stop();

      // R1: foreign address ignored, its data does not land
      bus_start();
      write_byte(8'hA0, ack, -1, 0);
      chk("R1 foreign address nack", 8'(ack), 8'd0);
      write_byte(8'h02, ack, -1, 0);
      chk("R1 ignored frame nack", 8'(ack), 8'd0);
      bus_stop();

      // R3 burst write
      write_regs(8'h03, 2, 8'hA5, 8'h5A, 8'h00, -1, 0);
      read_check("R3 burst");

      // R8 write to status ignored, R3 pointer wrap
      write_regs(8'h00, 1, 8'hFF, 8'h00, 8'h00, -1, 0);
      write_regs(8'h0F, 3, 8'hC1, 8'hC2, 8'hC3, -1, 0);
      read_check("R8 R3 wrap");

      // R7 repeated START chains write and read
      bus_start();
      write_byte(adr(lat_a2, lat_a1, 1'b0), ack, -1, 0);
      write_byte(8'h02, ack, -1, 0);
      write_byte(8'h3C, ack, -1, 0);
      chk("R7 write before Sr ack", 8'(ack), 8'd1);
      model[2] = 8'h3C;
      bus_start();
      write_byte(adr(lat_a2, lat_a1, 1'b1), ack, -1, 0);
      chk("R7 read after Sr ack", 8'(ack), 8'd1);
      for (int i = 0; i < 3; i++) begin
         read_byte(i != 2, v);
         chk("R7 chained read", v, model[i]);
      end
      bus_stop();

      // R10 glitches on SCL and on SDA
      write_regs(8'h05, 1, 8'h99, 8'h00, 8'h00, 0, 1);
      write_regs(8'h06, 1, 8'h6F, 8'h00, 8'h00, 0, 2);
      read_check("R10 glitch");

      // R6 general call with a non-reset code
      bus_start();
      write_byte(8'h00, ack, -1, 0);
      chk("R6 general call ack", 8'(ack), 8'd1);
      write_byte(8'h04, ack, -1, 0);
      chk("R6 other code nack", 8'(ack), 8'd0);
      bus_stop();
      read_check("R6 no effect");

      // R6 soft reset: defaults restored, straps re-sampled (0,1)
      bus_start();
      write_byte(8'h00, ack, -1, 0);
      write_byte(8'h06, ack, -1, 0);
      chk("R6 soft reset code ack", 8'(ack), 8'd1);
      bus_stop();
      lat_a2 = 1'b0; lat_a1 = 1'b1;
      model_reset();
      read_check("R6 R2 after soft reset");

      // random writes against the model
      for (int it = 0; it < 10; it++) begin
         n = 1 + int'($urandom % 3);
         write_regs(8'($urandom), n, 8'($urandom), 8'($urandom), 8'($urandom), -1, 0);
      end
      read_check("R3 random");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule